// File: doc/BRIEF.md
# Elastic Store Jitter Attenuator

This block smooths the timing of a two-rail line symbol stream. Symbols arrive on a write strobe that follows the jittery line clock. They are held in a small circular buffer and leave on a locally built read clock. That read clock is produced by dividing a reference tick that runs at eight times the bit rate. No crystal and no fast oscillator are involved. The read clock is steered only by the buffer's fill level. When the fill comes within two entries of full, one period is shortened by one tick. When it comes within two entries of empty, one period is lengthened by one tick. In both cases the step is an eighth of a bit.

The usable depth is 32 or 64 entries, picked by a select input. Enabling the block, or changing the depth while it is enabled, starts the buffer half full. The average delay is therefore half the depth. With the block disabled, symbols go straight from input to output. When the line signal is lost, the read clock stops correcting and settles on the nominal eight-tick period at the next period boundary. Overflow and underflow each set a sticky flag that a host status read clears. Each flag can raise a shared interrupt, and each has its own mask.

Top module: `es_jitter_buf`

## Requirements
- R1: With `ja_en` low, `rd_sym` equals `wr_sym` and `rd_stb` equals `wr_stb` in the same cycle.
- R2: On the cycle `ja_en` rises, the buffer is reloaded half full with symbol 00: 16 entries when `deep_sel`=0 (depth 32), 32 entries when `deep_sel`=1 (depth 64). The first half-depth output symbols are 00, followed by the written symbols in write order.
- R3: `rd_clk` changes only in the cycle after a `ref_tick` (or after a reload). It rises at the start of each period and stays high for 4 ticks. Each rise is followed one cycle later by a one-cycle `rd_stb` carrying the next symbol. While the fill stays between 3 and depth-3, the period is 8 ticks.
- R4: A period that starts with fill at or above depth-2 lasts 7 ticks. A period that starts with fill at or below 2 lasts 9 ticks. No period is ever shorter than 7 or longer than 9 ticks.
- R5: A write arriving with the buffer full and no read in that cycle is dropped, and `ovf_flag` is set.
- R6: A read with the buffer empty repeats the previous output symbol, and `unf_flag` is set.
- R7: `ovf_flag` and `unf_flag` stay set until the cycle after a `stat_rd` pulse. In that cycle they clear, unless a new event of the same kind happens at the same time.
- R8: `irq` is high when a set flag's mask input (`mask_ovf` or `mask_unf`) is low. A mask input at 1 keeps its flag from raising `irq`.
- R9: While `los` is high, every read clock period that starts is exactly 8 ticks, whatever the fill level.
- R10: Changing `deep_sel` clears both sticky flags on the next edge. If the block is enabled, it also reloads the buffer as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse at 8x the bit rate |
| wr_stb | input | 1 | Write strobe from the line-side clock |
| wr_sym | input | 2 | Symbol to write (positive and negative rail) |
| ja_en | input | 1 | 1 buffers and smooths; 0 bypasses |
| deep_sel | input | 1 | 0 selects depth 32, 1 selects depth 64 |
| los | input | 1 | Loss of signal: forces nominal period |
| stat_rd | input | 1 | Host status-read pulse; clears sticky flags |
| mask_ovf | input | 1 | 1 keeps overflow from raising irq |
| mask_unf | input | 1 | 1 keeps underflow from raising irq |
| rd_clk | output | 1 | Smoothed read clock |
| rd_stb | output | 1 | One-cycle pulse with each output symbol |
| rd_sym | output | 2 | Output symbol |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Masked interrupt |

## Verification
Writes are fed at fixed intervals of 16, 14, 18 and 8 system cycles against a read clock that is nominally 16 cycles. Matched rates show the half-full preload and the ordering at both depths. Faster and slower feeds must bring out only 7-tick and 9-tick periods, and the same slow feed with loss of signal must fall back to 8. The 8-cycle feed forces a real overflow and a stopped feed forces a real underflow with a repeated symbol. Together these separate wrong correction direction, missing bounds, bad reload depth and wrong sticky or mask behaviour.

// File: rtl/es_pkg.sv
`timescale 1ns/1ps
package es_pkg;
    typedef logic [1:0] sym_t;
    localparam int unsigned NOM_TICKS_DEF = 8;
endpackage

// File: rtl/es_clkgen.sv
`timescale 1ns/1ps
module es_clkgen #(
    parameter int unsigned NOM_TICKS = es_pkg::NOM_TICKS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic ref_tick,
    input  logic los,
    input  logic near_full,
    input  logic near_empty,
    output logic rd_clk,
    output logic rd_pulse
);
    localparam int unsigned PW = $clog2(NOM_TICKS + 2);
    localparam logic [PW-1:0] NOM  = PW'(NOM_TICKS);
    localparam logic [PW-1:0] HIGH = PW'(NOM_TICKS / 2);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic [PW-1:0] len;
        logic          pulse;
    } cg_t;

    cg_t cg_d, cg_q;

    always_comb begin
        cg_d       = cg_q;
        cg_d.pulse = 1'b0;
        if (restart) begin
            cg_d.phase = '0;
            cg_d.len   = NOM;
        end else if (ref_tick) begin
            if (cg_q.phase == cg_q.len - PW'(1)) begin
                cg_d.phase = '0;
                cg_d.pulse = 1'b1;
                // one correction per period, chosen at the period start
                if (los)             cg_d.len = NOM;
                else if (near_full)  cg_d.len = NOM - PW'(1);
                else if (near_empty) cg_d.len = NOM + PW'(1);
                else                 cg_d.len = NOM;
            end else begin
                cg_d.phase = cg_q.phase + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cg_q <= '{phase: '0, len: NOM, pulse: 1'b0};
        end else begin
            cg_q <= cg_d;
        end
    end

    assign rd_clk   = (cg_q.phase < HIGH);
    assign rd_pulse = cg_q.pulse;
endmodule

// File: rtl/es_store.sv
`timescale 1ns/1ps
module es_store #(
    parameter int unsigned DEPTH_MIN = 32,
    parameter int unsigned DEPTH_MAX = 64,
    parameter int unsigned GUARD     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         deep,
    input  logic         push,
    input  es_pkg::sym_t push_sym,
    input  logic         pop,
    output es_pkg::sym_t out_sym,
    output logic         out_stb,
    output logic         near_full,
    output logic         near_empty,
    output logic         ovf_evt,
    output logic         unf_evt
);
    localparam int unsigned AW = $clog2(DEPTH_MAX);
    localparam int unsigned CW = AW + 1;

    typedef struct packed {
        logic [DEPTH_MAX-1:0][1:0] mem;
        logic [AW-1:0]             rd;
        logic [AW-1:0]             wr;
        logic [CW-1:0]             cnt;
        es_pkg::sym_t              sym;
        logic                      stb;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] depth;
    logic          pop_ok, push_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                           input logic [CW-1:0] dep);
        return ({1'b0, p} == dep - CW'(1)) ? '0 : p + AW'(1);
    endfunction

    assign depth = deep ? CW'(DEPTH_MAX) : CW'(DEPTH_MIN);

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        ovf_evt  = 1'b0;
        unf_evt  = 1'b0;
        pop_ok   = 1'b0;
        push_ok  = 1'b0;
        if (init) begin
            st_d.mem = '0;
            st_d.rd  = '0;
            st_d.wr  = AW'(depth >> 1);
            st_d.cnt = depth >> 1;
        end else begin
            if (pop) begin
                st_d.stb = 1'b1;
                if (st_q.cnt != '0) begin
                    pop_ok   = 1'b1;
                    st_d.sym = st_q.mem[st_q.rd];
                    st_d.rd  = step(st_q.rd, depth);
                end else begin
                    unf_evt = 1'b1;   // keep previous symbol
                end
            end
            if (push) begin
                if ((st_q.cnt != depth) || pop_ok) begin
                    push_ok = 1'b1;
                    st_d.mem[st_q.wr] = push_sym;
                    st_d.wr = step(st_q.wr, depth);
                end else begin
                    ovf_evt = 1'b1;   // symbol dropped
                end
            end
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_sym    = st_q.sym;
    assign out_stb    = st_q.stb;
    assign near_full  = (st_q.cnt >= depth - CW'(GUARD));
    assign near_empty = (st_q.cnt <= CW'(GUARD));
endmodule

// File: rtl/es_status.sv
`timescale 1ns/1ps
module es_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ovf_evt,
    input  logic unf_evt,
    input  logic stat_rd,
    input  logic mask_ovf,
    input  logic mask_unf,
    output logic ovf_flag,
    output logic unf_flag,
    output logic irq
);
    typedef struct packed {
        logic ovf;
        logic unf;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr) begin
            fl_d = '0;
        end else begin
            if (stat_rd) fl_d = '0;
            if (ovf_evt) fl_d.ovf = 1'b1;   // new event wins over the read
            if (unf_evt) fl_d.unf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign ovf_flag = fl_q.ovf;
    assign unf_flag = fl_q.unf;
    assign irq      = (fl_q.ovf & ~mask_ovf) | (fl_q.unf & ~mask_unf);
endmodule

// File: rtl/es_jitter_buf.sv
`timescale 1ns/1ps
module es_jitter_buf #(
    parameter int unsigned DEPTH_MIN = 32,
    parameter int unsigned DEPTH_MAX = 64,
    parameter int unsigned GUARD     = 2,
    parameter int unsigned NOM_TICKS = es_pkg::NOM_TICKS_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       wr_stb,
    input  logic [1:0] wr_sym,
    input  logic       ja_en,
    input  logic       deep_sel,
    input  logic       los,
    input  logic       stat_rd,
    input  logic       mask_ovf,
    input  logic       mask_unf,
    output logic       rd_clk,
    output logic       rd_stb,
    output logic [1:0] rd_sym,
    output logic       ovf_flag,
    output logic       unf_flag,
    output logic       irq
);
    typedef struct packed {
        logic en;
        logic deep;
    } top_t;

    top_t tp_d, tp_q;
    logic init, depth_chg;
    logic rd_pulse, near_full, near_empty, ovf_evt, unf_evt;
    logic buf_stb;
    es_pkg::sym_t buf_sym;

    assign depth_chg = (deep_sel != tp_q.deep);
    assign init      = ja_en & (~tp_q.en | depth_chg);

    always_comb begin
        tp_d      = tp_q;
        tp_d.en   = ja_en;
        tp_d.deep = deep_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= '0;
        end else begin
            tp_q <= tp_d;
        end
    end

    es_clkgen #(.NOM_TICKS(NOM_TICKS)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (init),
        .ref_tick   (ref_tick),
        .los        (los),
        .near_full  (near_full),
        .near_empty (near_empty),
        .rd_clk     (rd_clk),
        .rd_pulse   (rd_pulse)
    );

    es_store #(.DEPTH_MIN(DEPTH_MIN), .DEPTH_MAX(DEPTH_MAX), .GUARD(GUARD)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .deep       (deep_sel),
        .push       (wr_stb & ja_en),
        .push_sym   (wr_sym),
        .pop        (rd_pulse & ja_en),
        .out_sym    (buf_sym),
        .out_stb    (buf_stb),
        .near_full  (near_full),
        .near_empty (near_empty),
        .ovf_evt    (ovf_evt),
        .unf_evt    (unf_evt)
    );

    es_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (depth_chg),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt),
        .stat_rd  (stat_rd),
        .mask_ovf (mask_ovf),
        .mask_unf (mask_unf),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag),
        .irq      (irq)
    );

    assign rd_sym = ja_en ? buf_sym : wr_sym;
    assign rd_stb = ja_en ? buf_stb : wr_stb;
endmodule

// File: rtl/es_jitter_chk.sv
`timescale 1ns/1ps
module es_jitter_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic rd_clk,
    input logic init,
    input logic depth_chg,
    input logic stat_rd,
    input logic ovf_flag,
    input logic unf_flag,
    input logic irq
);
    logic       clk_prev, seen;
    logic [4:0] ticks;
    logic       rise;

    assign rise = rd_clk & ~clk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev <= 1'b1;
            seen     <= 1'b0;
            ticks    <= '0;
        end else begin
            clk_prev <= rd_clk;
            if (init)      seen <= 1'b0;
            else if (rise) seen <= 1'b1;
            if (rise) ticks <= {4'b0, ref_tick};
            else      ticks <= ticks + {4'b0, ref_tick};
        end
    end

    // R3: read clock moves only after a tick or a reload
    a_r3_clk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ref_tick) && !$past(init)) |-> $stable(rd_clk));

    // R4: every measured period lies within 7..9 ticks
    a_r4_period_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen && !init) |-> (ticks >= 5'd7 && ticks <= 5'd9));

    // R7: sticky overflow flag
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !stat_rd && !depth_chg) |=> ovf_flag);

    // R7: sticky underflow flag
    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !stat_rd && !depth_chg) |=> unf_flag);

    // R8: no interrupt without a flag
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !unf_flag) |-> !irq);
endmodule

bind es_jitter_buf es_jitter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .rd_clk    (rd_clk),
    .init      (init),
    .depth_chg (depth_chg),
    .stat_rd   (stat_rd),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag),
    .irq       (irq)
);

// File: tb/sim_es_jitter_buf.sv
`timescale 1ns/1ps
module sim_es_jitter_buf;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0, wr_stb = 1'b0, ja_en = 1'b0, deep_sel = 1'b0;
    logic los = 1'b0, stat_rd = 1'b0, mask_ovf = 1'b0, mask_unf = 1'b0;
    logic [1:0] wr_sym = 2'b00;
    logic rd_clk, rd_stb, ovf_flag, unf_flag, irq;
    logic [1:0] rd_sym;

    int n_chk = 0, n_bad = 0;
    int gap = 0, wcnt = 0, wk = 0, rj = 0, half = 16;
    bit chk_order = 0, meas_en = 0, have_rise = 0, prev_clk = 1;
    int cyc = 0, last_rise = 0, pmin = 1000, pmax = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    es_jitter_buf u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_stb(wr_stb),
        .wr_sym(wr_sym), .ja_en(ja_en), .deep_sel(deep_sel), .los(los),
        .stat_rd(stat_rd), .mask_ovf(mask_ovf), .mask_unf(mask_unf),
        .rd_clk(rd_clk), .rd_stb(rd_stb), .rd_sym(rd_sym),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag), .irq(irq)
    );

    function automatic logic [1:0] symf(input int k);
        return 2'((k * 3 + k / 5) % 4);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference tick every other cycle: 8 ticks = 16 cycles per bit
    initial forever begin
        @(negedge clk);
        ref_tick = ~ref_tick;
    end

    // writer at a programmable interval
    initial forever begin
        @(negedge clk);
        wr_stb = 1'b0;
        if (gap != 0) begin
            wcnt++;
            if (wcnt >= gap) begin
                wcnt   = 0;
                wr_stb = 1'b1;
                wr_sym = symf(wk);
                wk++;
            end
        end
    end

    // order monitor and period measurement
    initial forever begin
        @(negedge clk);
        cyc++;
        if (chk_order && rd_stb) begin
            logic [1:0] e;
            e = (rj < half) ? 2'b00 : symf(rj - half);
            check(rd_sym == e, "R2 order", rd_sym, e);
            rj++;
        end
        if (rd_clk && !prev_clk) begin
            if (meas_en && have_rise) begin
                if (cyc - last_rise < pmin) pmin = cyc - last_rise;
                if (cyc - last_rise > pmax) pmax = cyc - last_rise;
            end
            last_rise = cyc;
            have_rise = 1;
        end
        prev_clk = rd_clk;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic meas_reset();
        have_rise = 0; pmin = 1000; pmax = 0; meas_en = 1;
    endtask

    task automatic start_run(input bit deep, input int g);
        chk_order = 0; gap = 0; meas_en = 0;
        cycles(2);
        ja_en = 0;
        cycles(2);
        deep_sel = deep;
        cycles(2);
        wk = 0; rj = 0; wcnt = 0; half = deep ? 32 : 16;
        ja_en = 1;
        chk_order = 1;
        gap = g;
    endtask

    task automatic pulse_rd();
        stat_rd = 1; cycles(1); stat_rd = 0;
    endtask

    initial begin
        cycles(10);
        rst_n = 1;
        cycles(4);
        // reset state
        check(ovf_flag == 0, "R7 reset ovf", ovf_flag, 0);
        check(unf_flag == 0, "R7 reset unf", unf_flag, 0);
        check(irq == 0, "R8 reset irq", irq, 0);

        // R1 bypass
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            wr_stb = 1; wr_sym = 2'(i);
            #1;
            check(rd_sym == 2'(i), "R1 bypass sym", rd_sym, i);
            check(rd_stb == 1, "R1 bypass stb", rd_stb, 1);
        end
        cycles(2);

        // R2/R3 depth 32, matched rate
        start_run(0, 16);
        cycles(200);
        meas_reset();
        cycles(700);
        check(pmin == 16 && pmax == 16, "R3 nominal period min", pmin, 16);
        check(pmax == 16, "R3 nominal period max", pmax, 16);

        // R6 underflow: stop feeding, drain
        chk_order = 0; gap = 0;
        cycles(900);
        check(unf_flag == 1, "R6 unf flag", unf_flag, 1);
        for (int i = 0; i < 3; i++) begin
            do @(negedge clk); while (!rd_stb);
            check(rd_sym == symf(wk - 1), "R6 repeat last", rd_sym, symf(wk - 1));
        end

        // R8 masking of underflow
        mask_unf = 1; cycles(1);
        check(irq == 0, "R8 unf masked", irq, 0);
        mask_unf = 0; cycles(1);
        check(irq == 1, "R8 unf unmasked", irq, 1);

        // R10 depth change clears flags
        deep_sel = 1; cycles(1);
        check(unf_flag == 0, "R10 unf cleared", unf_flag, 0);
        check(ovf_flag == 0, "R10 ovf cleared", ovf_flag, 0);

        // R2 depth 64
        start_run(1, 16);
        cycles(1100);

        // R4 slow feed -> 9 tick periods
        start_run(0, 18);
        cycles(200);
        chk_order = 0;
        cycles(2800);
        meas_reset();
        cycles(700);
        check(pmax == 18, "R4 slow max period", pmax, 18);
        check(pmin >= 16, "R4 slow min period", pmin, 16);

        // R9 loss of signal -> nominal
        los = 1;
        cycles(40);
        meas_reset();
        cycles(500);
        check(pmin == 16, "R9 los min period", pmin, 16);
        check(pmax == 16, "R9 los max period", pmax, 16);
        los = 0;

        // R4 fast feed -> 7 tick periods
        start_run(0, 14);
        cycles(200);
        chk_order = 0;
        cycles(2300);
        meas_reset();
        cycles(700);
        check(pmin == 14, "R4 fast min period", pmin, 14);
        check(pmax <= 16, "R4 fast max period", pmax, 16);

        // R5 overflow
        pulse_rd();
        mask_ovf = 1;
        gap = 8;
        cycles(1500);
        check(ovf_flag == 1, "R5 ovf flag", ovf_flag, 1);
        check(irq == 0, "R8 ovf masked", irq, 0);
        mask_ovf = 0; cycles(1);
        check(irq == 1, "R8 ovf unmasked", irq, 1);

        // R7 status read clears
        gap = 0;
        cycles(5);
        pulse_rd();
        check(ovf_flag == 0, "R7 ovf cleared by read", ovf_flag, 0);
        check(unf_flag == 0, "R7 unf clear", unf_flag, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule